// File: doc/BRIEF.md
# Serial Flash Clock and Select Timing Generator

This block produces the serial clock, the active-low device select lines and the spacing between frames for a serial flash master. It runs on a reference clock. A transfer engine asks for a frame by giving a number of serial-clock edges. The block then drives the chosen select line low and waits out a programmable lead time. It toggles the serial clock for exactly the requested number of edges. It then holds the select for a programmable tail time and keeps all selects high for a programmable gap before it reports idle again. On every serial-clock edge it sends a one-cycle strobe to the shifter, and it marks whether that edge samples data or launches it.

The serial clock runs at the reference clock divided by twice one more than a 4-bit divisor. Polarity sets the rest level of the clock. Phase sets which edges are the sampling ones. The 4-bit select value is either a direct active-low pin pattern or a device number that the block decodes. If a frame targets a different select pattern from the previous frame, an extra changeover wait comes before the select is asserted. All configuration inputs are expected to change only while the enable input is low. The select pattern and edge count are captured when a request is accepted.

Top module: `sflash_timing_gen`

## Requirements
- R1: With divisor N on `baud_div`, consecutive edge strobes are exactly N+1 reference cycles apart, so one serial-clock period is 2·(N+1) cycles (N=0 gives reference/2, N=15 gives reference/32).
- R2: With `sel_decode`=0, `sel_n` carries `sel_field` bit for bit while a frame holds the select (for example 4'b1101 drives line 1 low), and it does not change while asserted.
- R3: With `sel_decode`=1 and `sel_field`=k with k below 4, only `sel_n[k]` goes low during the frame (k=2 gives 4'b1011).
- R4: With `sel_decode`=1 and a `sel_field` value of 4 or more, no select line goes low, yet the frame still produces all its clock edges.
- R5: While idle, `sclk` rests at `cpol`. The first edge of a frame moves it away from that level (falling when `cpol`=1).
- R6: `edge_smp` is 1 on sampling edges. With `cpha`=0 these are the 1st, 3rd, ... edges, and with `cpha`=1 the 2nd, 4th, ... edges.
- R7: From the first cycle the select is low to the first edge strobe is `dly_setup`+N+2 reference cycles.
- R8: From the last edge strobe to the first cycle with all selects high is `dly_hold`+1 reference cycles.
- R9: From the first cycle with all selects high to `idle`=1 is `dly_gap`+1 reference cycles. While `idle`=1, all select lines are high.
- R10: If the accepted pattern differs from the previous frame's pattern, the select goes low `dly_switch`+1 cycles after `idle` falls. Otherwise, and on the first frame after reset, it goes low in the same cycle that `idle` falls.
- R11: A request is accepted only when `en`=1 and `idle`=1. A request made while disabled or during a frame is ignored and starts no frame.
- R12: A frame gives exactly `frame_edges` edge strobes, each coinciding with a toggle of `sclk`. With 0 edges, the select stays low for `dly_setup`+`dly_hold`+2 cycles and no strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global enable; requests are accepted only while high |
| baud_div | input | 4 | Divisor N; serial clock = reference / (2·(N+1)) |
| cpol | input | 1 | Rest level of the serial clock |
| cpha | input | 1 | 0: odd edges sample; 1: even edges sample |
| sel_field | input | 4 | Select pattern (direct) or device number (decoded) |
| sel_decode | input | 1 | 1: treat sel_field as a device number |
| dly_setup | input | 8 | Select-low to first-edge delay count |
| dly_hold | input | 8 | Last-edge to select-high delay count |
| dly_gap | input | 8 | Minimum all-high time after a frame |
| dly_switch | input | 8 | Extra wait before selecting a different device |
| frame_req | input | 1 | Frame request, sampled while idle |
| frame_edges | input | 8 | Number of serial-clock edges in the requested frame |
| sclk | output | 1 | Serial clock |
| sel_n | output | 4 | Active-low device select lines |
| edge_stb | output | 1 | One-cycle strobe on each serial-clock edge |
| edge_smp | output | 1 | Qualifies edge_stb: 1 on a sampling edge |
| idle | output | 1 | High when no frame or post-frame delay is pending |

## Verification
The frame is driven with the fastest divisor and zero delays, and with the slowest divisor and distinct non-zero setup, hold and gap counts. Because each count is different, an off-by-one in any single phase shows up as a wrong interval on only that phase. Polarity and phase are tried in three combinations, which separates the rest level, the direction of the first edge and the sampling-edge parity. Direct and decoded selects, an out-of-range device number, repeated versus changed devices, zero-edge frames, and requests made while disabled or busy each isolate one select or acceptance rule.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SWITCH = 3'd1,
    ST_SETUP  = 3'd2,
    ST_CLOCK  = 3'd3,
    ST_HOLD   = 3'd4,
    ST_GAP    = 3'd5
  } sfg_state_e;

  // An edge samples data when its parity (0 = first edge) equals the phase bit.
  function automatic logic is_sample_edge(input logic parity, input logic phase);
    return parity == phase;
  endfunction

  // Phases during which the selected line is driven low.
  function automatic logic holds_select(input sfg_state_e st);
    return (st == ST_SETUP) || (st == ST_CLOCK) || (st == ST_HOLD);
  endfunction

endpackage

// File: rtl/sfg_sel_map.sv
module sfg_sel_map #(
  parameter int CS_W = 4
) (
  input  logic [CS_W-1:0] field,
  input  logic            decode,
  output logic [CS_W-1:0] pat_n
);

  for (genvar i = 0; i < CS_W; i++) begin : g_pin
    // decoded: line i low only when field equals i; direct: pass through
    assign pat_n[i] = decode ? (field != CS_W'(i)) : field[i];
  end

endmodule

// File: rtl/sfg_phase_cnt.sv
module sfg_phase_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sfg_half_div.sv
module sfg_half_div #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] div,
  output logic         tick
);

  logic [W-1:0] hcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hcnt_q <= '0;
    else if (load)    hcnt_q <= div;
    else if (run)     hcnt_q <= (hcnt_q == '0) ? div : hcnt_q - 1'b1;
  end

  assign tick = run && (hcnt_q == '0);

endmodule

// File: rtl/sflash_timing_gen.sv
module sflash_timing_gen #(
  parameter int CS_W   = 4,
  parameter int DIV_W  = 4,
  parameter int DLY_W  = 8,
  parameter int EDGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [CS_W-1:0]   sel_field,
  input  logic              sel_decode,
  input  logic [DLY_W-1:0]  dly_setup,
  input  logic [DLY_W-1:0]  dly_hold,
  input  logic [DLY_W-1:0]  dly_gap,
  input  logic [DLY_W-1:0]  dly_switch,
  input  logic              frame_req,
  input  logic [EDGE_W-1:0] frame_edges,
  output logic              sclk,
  output logic [CS_W-1:0]   sel_n,
  output logic              edge_stb,
  output logic              edge_smp,
  output logic              idle
);
  import sfg_pkg::*;

  localparam logic [CS_W-1:0]   ALL_HIGH  = {CS_W{1'b1}};
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(1);

  sfg_state_e        state_q, state_d;
  logic [CS_W-1:0]   new_pat;
  logic [CS_W-1:0]   cur_pat_q, last_pat_q;
  logic              had_prev_q;
  logic [EDGE_W-1:0] cur_edges_q, edges_left_q;
  logic              parity_q;

  // named internal events
  logic              frame_accept;
  logic              dev_change;
  logic              ph_zero;
  logic              ph_load;
  logic [DLY_W-1:0]  ph_val;
  logic              clk_load;
  logic              tick;
  logic              in_clock;

  sfg_sel_map #(.CS_W(CS_W)) i_sel_map (
    .field  (sel_field),
    .decode (sel_decode),
    .pat_n  (new_pat)
  );

  sfg_phase_cnt #(.W(DLY_W)) i_phase_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ph_load),
    .val   (ph_val),
    .zero  (ph_zero)
  );

  sfg_half_div #(.W(DIV_W)) i_half_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (in_clock),
    .load  (clk_load),
    .div   (baud_div),
    .tick  (tick)
  );

  assign in_clock     = (state_q == ST_CLOCK);
  assign frame_accept = (state_q == ST_IDLE) && en && frame_req;
  assign dev_change   = had_prev_q && (new_pat != last_pat_q);
  assign clk_load     = (state_q == ST_SETUP) && ph_zero && (cur_edges_q != '0);

  always_comb begin
    state_d = state_q;
    ph_load = 1'b0;
    ph_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (frame_accept) begin
          ph_load = 1'b1;
          if (dev_change) begin
            state_d = ST_SWITCH;
            ph_val  = dly_switch;
          end else begin
            state_d = ST_SETUP;
            ph_val  = dly_setup;
          end
        end
      end
      ST_SWITCH: begin
        if (ph_zero) begin
          state_d = ST_SETUP;
          ph_load = 1'b1;
          ph_val  = dly_setup;
        end
      end
      ST_SETUP: begin
        if (ph_zero) begin
          if (cur_edges_q == '0) begin
            state_d = ST_HOLD;
            ph_load = 1'b1;
            ph_val  = dly_hold;
          end else begin
            state_d = ST_CLOCK;
          end
        end
      end
      ST_CLOCK: begin
        if (tick && edges_left_q == LAST_EDGE) begin
          state_d = ST_HOLD;
          ph_load = 1'b1;
          ph_val  = dly_hold;
        end
      end
      ST_HOLD: begin
        if (ph_zero) begin
          state_d = ST_GAP;
          ph_load = 1'b1;
          ph_val  = dly_gap;
        end
      end
      ST_GAP: begin
        if (ph_zero) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      cur_pat_q    <= ALL_HIGH;
      last_pat_q   <= ALL_HIGH;
      had_prev_q   <= 1'b0;
      cur_edges_q  <= '0;
      edges_left_q <= '0;
      parity_q     <= 1'b0;
      sclk         <= 1'b0;
      edge_stb     <= 1'b0;
      edge_smp     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (frame_accept) begin
        cur_pat_q   <= new_pat;
        last_pat_q  <= new_pat;
        had_prev_q  <= 1'b1;
        cur_edges_q <= frame_edges;
      end
      if (clk_load) begin
        edges_left_q <= cur_edges_q;
        parity_q     <= 1'b0;
      end else if (tick) begin
        edges_left_q <= edges_left_q - 1'b1;
        parity_q     <= ~parity_q;
      end
      if (!in_clock)  sclk <= cpol;
      else if (tick)  sclk <= ~sclk;
      edge_stb <= tick;
      edge_smp <= tick && is_sample_edge(parity_q, cpha);
    end
  end

  assign sel_n = holds_select(state_q) ? cur_pat_q : ALL_HIGH;
  assign idle  = (state_q == ST_IDLE);

endmodule

// File: rtl/sfg_chk.sv
module sfg_chk #(
  parameter int CS_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic            cpol,
  input logic            frame_req,
  input logic            frame_accept,
  input logic            idle,
  input logic            sclk,
  input logic [CS_W-1:0] sel_n,
  input logic            edge_stb
);

  logic warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= 1'b0;
    else        warm_q <= 1'b1;
  end

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (sel_n == {CS_W{1'b1}}));  // R9

  AST_ACCEPT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle) |-> $past(frame_req && en));  // R11

  AST_ACCEPT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_accept |=> !idle);  // R11

  AST_EDGE_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    edge_stb |-> !$stable(sclk));  // R12

  AST_NO_EDGE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_stb |-> !idle);  // R12

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_n != {CS_W{1'b1}}) && ($past(sel_n) != {CS_W{1'b1}})) |-> $stable(sel_n));  // R2

  AST_REST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q && idle && $past(idle) && $stable(cpol)) |-> (sclk == cpol));  // R5

endmodule

bind sflash_timing_gen sfg_chk #(.CS_W(CS_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en           (en),
  .cpol         (cpol),
  .frame_req    (frame_req),
  .frame_accept (frame_accept),
  .idle         (idle),
  .sclk         (sclk),
  .sel_n        (sel_n),
  .edge_stb     (edge_stb)
);

// File: tb/test_sflash_timing_gen.sv
module test_sflash_timing_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [3:0] baud_div = '0;
  logic       cpol = 1'b0, cpha = 1'b0;
  logic [3:0] sel_field = 4'hF;
  logic       sel_decode = 1'b0;
  logic [7:0] dly_setup = '0, dly_hold = '0, dly_gap = '0, dly_switch = '0;
  logic       frame_req = 1'b0;
  logic [7:0] frame_edges = '0;
  logic       sclk, edge_stb, edge_smp, idle;
  logic [3:0] sel_n;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sflash_timing_gen i_sflash_timing_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .baud_div(baud_div), .cpol(cpol), .cpha(cpha),
    .sel_field(sel_field), .sel_decode(sel_decode), .dly_setup(dly_setup),
    .dly_hold(dly_hold), .dly_gap(dly_gap), .dly_switch(dly_switch),
    .frame_req(frame_req), .frame_edges(frame_edges), .sclk(sclk), .sel_n(sel_n),
    .edge_stb(edge_stb), .edge_smp(edge_smp), .idle(idle)
  );

  // frame monitor, sampled away from the active edge
  bit mon_on = 0;
  int m_if, m_cs, m_first, m_last, m_off, m_idle, m_edges, m_smp;
  int m_first_lvl, m_first_smp, m_spmin, m_spmax, m_pat, m_cs_cyc, m_falls, m_prev_idle;
  int pre_lvl;

  task automatic clear_mon();
    m_if = -1; m_cs = -1; m_first = -1; m_last = -1; m_off = -1; m_idle = -1;
    m_edges = 0; m_smp = 0; m_first_lvl = -1; m_first_smp = -1;
    m_spmin = 1 << 30; m_spmax = 0; m_pat = -1; m_cs_cyc = 0; m_falls = 0;
    m_prev_idle = 1; mon_on = 1;
  endtask

  always @(negedge clk) if (mon_on) begin
    if (!idle && m_prev_idle == 1) begin
      m_falls++;
      if (m_if < 0) m_if = cyc;
    end
    m_prev_idle = idle;
    if (sel_n != 4'hF) begin
      m_cs_cyc++;
      if (m_cs < 0) begin m_cs = cyc; m_pat = sel_n; end
    end else if (m_cs >= 0 && m_off < 0) m_off = cyc;
    if (edge_stb) begin
      m_edges++;
      if (m_edges == 1) begin m_first = cyc; m_first_lvl = sclk; m_first_smp = edge_smp; end
      else begin
        if (cyc - m_last < m_spmin) m_spmin = cyc - m_last;
        if (cyc - m_last > m_spmax) m_spmax = cyc - m_last;
      end
      m_last = cyc;
      if (edge_smp) m_smp++;
    end
    if (idle && m_if >= 0 && m_idle < 0) m_idle = cyc;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_frame(input int e, input int n, input int s, input int h, input int g,
                          input int w, input bit pol, input bit pha,
                          input logic [3:0] fld, input bit dec);
    @(negedge clk);
    en = 0;
    baud_div = 4'(n); dly_setup = 8'(s); dly_hold = 8'(h); dly_gap = 8'(g);
    dly_switch = 8'(w); cpol = pol; cpha = pha; sel_field = fld; sel_decode = dec;
    @(negedge clk);
    en = 1;
    repeat (2) @(negedge clk);
    pre_lvl = sclk;
    clear_mon();
    frame_req = 1; frame_edges = 8'(e);
    @(negedge clk);
    frame_req = 0;
    while (!idle) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic sc_reset();
    chk(idle == 1, "R9 idle after reset", idle, 1);
    chk(sel_n == 4'hF, "R9 selects high after reset", sel_n, 15);
    chk(edge_stb == 0, "R12 no strobe after reset", edge_stb, 0);
    chk(sclk == 0, "R5 rest level after reset", sclk, 0);
  endtask

  task automatic sc_fast();
    do_frame(8, 0, 0, 0, 0, 6, 0, 0, 4'b1101, 0);
    chk(m_pat == 13, "R2 direct pattern", m_pat, 13);
    chk(m_spmin == 1 && m_spmax == 1, "R1 spacing N=0", m_spmax, 1);
    chk(m_edges == 8, "R12 edge count", m_edges, 8);
    chk(m_first - m_cs == 2, "R7 setup 0", m_first - m_cs, 2);
    chk(m_off - m_last == 1, "R8 hold 0", m_off - m_last, 1);
    chk(m_idle - m_off == 1, "R9 gap 0", m_idle - m_off, 1);
    chk(m_cs == m_if, "R10 no wait on first frame", m_cs - m_if, 0);
  endtask

  task automatic sc_slow();
    do_frame(4, 15, 3, 5, 7, 9, 0, 0, 4'b1101, 0);
    chk(m_spmin == 16 && m_spmax == 16, "R1 spacing N=15", m_spmin, 16);
    chk(m_first - m_cs == 3 + 15 + 2, "R7 setup 3", m_first - m_cs, 20);
    chk(m_off - m_last == 6, "R8 hold 5", m_off - m_last, 6);
    chk(m_idle - m_off == 8, "R9 gap 7", m_idle - m_off, 8);
    chk(m_cs == m_if, "R10 same device no wait", m_cs - m_if, 0);
    chk(m_first_lvl == 1, "R5 first edge rises cpol=0", m_first_lvl, 1);
  endtask

  task automatic sc_modes();
    do_frame(4, 1, 1, 1, 1, 0, 1, 1, 4'b1101, 0);
    chk(pre_lvl == 1, "R5 rest level cpol=1", pre_lvl, 1);
    chk(m_first_lvl == 0, "R5 first edge falls cpol=1", m_first_lvl, 0);
    chk(m_first_smp == 0, "R6 cpha=1 first edge launches", m_first_smp, 0);
    chk(m_smp == 2, "R6 cpha=1 sample count", m_smp, 2);
    chk(m_spmin == 2 && m_spmax == 2, "R1 spacing N=1", m_spmax, 2);
    do_frame(6, 2, 0, 0, 0, 0, 1, 0, 4'b1101, 0);
    chk(m_first_smp == 1, "R6 cpha=0 first edge samples", m_first_smp, 1);
    chk(m_smp == 3, "R6 cpha=0 sample count", m_smp, 3);
    chk(sclk == 1, "R5 back at rest after frame", sclk, 1);
  endtask

  task automatic sc_decode();
    do_frame(2, 0, 1, 1, 1, 4, 0, 0, 4'd2, 1);
    chk(m_pat == 11, "R3 decoded device 2", m_pat, 11);
    chk(m_cs - m_if == 5, "R10 changeover wait", m_cs - m_if, 5);
    do_frame(2, 0, 1, 1, 1, 4, 0, 0, 4'd2, 1);
    chk(m_cs - m_if == 0, "R10 repeat device no wait", m_cs - m_if, 0);
    do_frame(2, 0, 0, 0, 0, 0, 0, 0, 4'd0, 1);
    chk(m_pat == 14, "R3 decoded device 0", m_pat, 14);
  endtask

  task automatic sc_out_of_range();
    do_frame(6, 0, 1, 1, 1, 2, 0, 0, 4'd6, 1);
    chk(m_cs_cyc == 0, "R4 no line low", m_cs_cyc, 0);
    chk(m_edges == 6, "R4 edges still produced", m_edges, 6);
  endtask

  task automatic sc_zero_edges();
    do_frame(0, 3, 4, 2, 1, 0, 0, 0, 4'b0111, 0);
    chk(m_edges == 0, "R12 no strobe for 0 edges", m_edges, 0);
    chk(m_off - m_cs == 4 + 2 + 2, "R12 select span 0 edges", m_off - m_cs, 8);
    chk(m_pat == 7, "R2 direct device 3", m_pat, 7);
  endtask

  task automatic sc_disabled();
    @(negedge clk);
    en = 0;
    clear_mon();
    frame_req = 1; frame_edges = 8'd4;
    @(negedge clk);
    frame_req = 0;
    repeat (20) @(negedge clk);
    chk(m_falls == 0, "R11 ignored while disabled", m_falls, 0);
    chk(m_edges == 0 && sel_n == 4'hF, "R11 no activity while disabled", m_edges, 0);
    chk(idle == 1, "R11 stays idle while disabled", idle, 1);
  endtask

  task automatic sc_busy();
    fork
      do_frame(8, 3, 2, 1, 1, 0, 0, 0, 4'b0111, 0);
      begin
        repeat (12) @(negedge clk);
        frame_req = 1; frame_edges = 8'd2;
        @(negedge clk);
        frame_req = 0;
      end
    join
    repeat (20) @(negedge clk);
    chk(m_falls == 1, "R11 busy request ignored", m_falls, 1);
    chk(m_edges == 8, "R11 busy frame edges", m_edges, 8);
    chk(idle == 1, "R11 idle after busy frame", idle, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    sc_reset();
    sc_fast();
    sc_slow();
    sc_modes();
    sc_decode();
    sc_out_of_range();
    sc_zero_edges();
    sc_disabled();
    sc_busy();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule